// File: doc/BRIEF.md
# Double-Buffered Two-Layer Bitmap Compositor

The block holds two 8-bit-per-pixel bitmap layers, a background and a foreground. Each layer has two banks, so it forms a double buffer. A host writes bytes into the back bank while the display scan reads the front bank. A one-bit buffer select decides which bank is which. Two strobe inputs control the select: one sets it and the other clears it. The host draws a whole frame in the back bank and then flips the select to show it.

On the scan side the block takes a pixel coordinate and returns a 9-bit palette index two clock cycles later. A nonzero foreground pixel is returned as it is, with bit 8 clear. Where the foreground pixel is zero it is transparent, and the background pixel shows through with bit 8 set. Host writes of 0xFF to the foreground layer are dropped. This lets overlapping sprite pixels be drawn without overwriting what is already there.

The full-size frame is 512x256 (XB=9, YB=8). The defaults are smaller to keep the memories small. A full-size display normally shows a 384x240 region of it.

Top module: `bitmap_compositor`

## Requirements
- R1: While reset is asserted and after it is released, `buf_sel` is 0 and `scan_index` is 0x100.
- R2: All bitmap memory starts at zero, so a pixel never written reads as index 0x100.
- R3: A host write stores into bank `buf_sel` of the selected layer. The scan reads bank `~buf_sel`, so a write is not visible until the select flips.
- R4: A `buf_set` pulse makes `buf_sel` 1 on the next cycle and a `buf_clr` pulse makes it 0. When both are high, set wins. When neither is high, the select holds.
- R5: A foreground write (`wr_fg`=1) with data 0xFF is discarded and the stored byte is kept. A background write (`wr_fg`=0) stores any value, 0xFF included.
- R6: When the foreground byte is nonzero, the index is {1'b0, fg}. Otherwise it is {1'b1, bg}.
- R7: `scan_index` reflects the `scan_x`/`scan_y` presented exactly two rising edges earlier.
- R8: A host write and a scan read in the same cycle do not affect each other, even at the same address.
- R9: The host pixel address is {y, x}, with x in the low XB bits. It matches the scan coordinate (`scan_y`, `scan_x`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write enable |
| wr_fg | input | 1 | Layer select: 1 foreground, 0 background |
| wr_addr | input | XB+YB | Pixel address {y, x} |
| wr_data | input | 8 | Pixel byte |
| buf_set | input | 1 | Strobe that sets the buffer select |
| buf_clr | input | 1 | Strobe that clears the buffer select |
| buf_sel | output | 1 | Current back bank (the bank host writes go to) |
| scan_x | input | XB | Scan column |
| scan_y | input | YB | Scan row |
| scan_index | output | 9 | Composited palette index |

## Verification
Pixels are tried under four combinations of values:
- background only, which checks that bit 8 is forced;
- foreground over background, which checks priority;
- a foreground 0xFF write over an earlier foreground value, which separates dropping the write from storing it;
- a background 0xFF, which shows that only the foreground layer filters 0xFF.

Each pattern is read before and after a select flip, which separates the back bank from the front bank. A write and a read at the same address in the same cycle check that the two banks are isolated. Back-to-back scan addresses with different values pin the latency to exactly two cycles. The corner pixel at maximum x and y checks the address layout.

// File: rtl/bitmap_compositor.sv
module bitmap_compositor #(
  parameter int XB = 5,
  parameter int YB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_fg,
  input  logic [XB+YB-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          buf_set,
  input  logic          buf_clr,
  output logic          buf_sel,
  input  logic [XB-1:0] scan_x,
  input  logic [YB-1:0] scan_y,
  output logic [8:0]    scan_index
);
  localparam int AW = XB + YB;
  localparam int DEPTH = 1 << AW;

  logic [7:0] bg_mem [2][DEPTH];
  logic [7:0] fg_mem [2][DEPTH];
  logic [7:0] bg_q, fg_q;
  logic [AW-1:0] rd_addr;
  logic front;

  assign rd_addr = {scan_y, scan_x};
  assign front   = ~buf_sel;

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) begin
        bg_mem[b][i] = 8'h00;
        fg_mem[b][i] = 8'h00;
      end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wr_fg) bg_mem[buf_sel][wr_addr] <= wr_data;
    if (wr_en && wr_fg && wr_data != 8'hFF) fg_mem[buf_sel][wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_sel <= 1'b0;
    else if (buf_set) buf_sel <= 1'b1;
    else if (buf_clr) buf_sel <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_q       <= 8'h00;
      fg_q       <= 8'h00;
      scan_index <= 9'h100;
    end else begin
      bg_q       <= bg_mem[front][rd_addr];
      fg_q       <= fg_mem[front][rd_addr];
      scan_index <= (fg_q != 8'h00) ? {1'b0, fg_q} : {1'b1, bg_q};
    end
  end

  AST_RESET_SEL: assert property (@(posedge clk) !rst_n |=> (!buf_sel && scan_index == 9'h100)); // R1
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) buf_set |=> buf_sel); // R4
  AST_CLR: assert property (@(posedge clk) disable iff (!rst_n) (buf_clr && !buf_set) |=> !buf_sel); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!buf_set && !buf_clr) |=> $stable(buf_sel)); // R4
  AST_FG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) !scan_index[8] |-> scan_index[7:0] != 8'h00); // R6
endmodule

// File: tb/bitmap_compositor_tb.sv
module bitmap_compositor_tb;
  localparam int XB = 5;
  localparam int YB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_fg = 1'b0;
  logic [XB+YB-1:0] wr_addr = '0;
  logic [7:0] wr_data = 8'h00;
  logic buf_set = 1'b0, buf_clr = 1'b0;
  logic buf_sel;
  logic [XB-1:0] scan_x = '0;
  logic [YB-1:0] scan_y = '0;
  logic [8:0] scan_index;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bitmap_compositor #(.XB(XB), .YB(YB)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fg(wr_fg), .wr_addr(wr_addr),
    .wr_data(wr_data), .buf_set(buf_set), .buf_clr(buf_clr), .buf_sel(buf_sel),
    .scan_x(scan_x), .scan_y(scan_y), .scan_index(scan_index));

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic fg, input int y, input int x, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_fg = fg; wr_addr = {y[YB-1:0], x[XB-1:0]}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input logic s, input logic c);
    @(negedge clk);
    buf_set = s; buf_clr = c;
    @(negedge clk);
    buf_set = 1'b0; buf_clr = 1'b0;
  endtask

  task automatic read_chk(input string req, input int y, input int x, input logic [8:0] exp);
    @(negedge clk);
    scan_x = x[XB-1:0]; scan_y = y[YB-1:0];
    @(negedge clk);
    @(negedge clk);
    check(req, scan_index, exp);
  endtask

  task automatic t_reset;
    check("R1 buf_sel", {8'h0, buf_sel}, 9'h000);
    check("R1 index", scan_index, 9'h100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", scan_index, 9'h100);
    read_chk("R2 unwritten", 3, 7, 9'h100);
  endtask

  task automatic t_compose;
    hwrite(1'b0, 1, 2, 8'h5A);
    hwrite(1'b0, 1, 3, 8'h10);
    hwrite(1'b1, 1, 3, 8'h33);
    hwrite(1'b1, 1, 4, 8'h44);
    hwrite(1'b1, 1, 4, 8'hFF);
    hwrite(1'b0, 1, 5, 8'hFF);
    hwrite(1'b0, YB == 0 ? 0 : (1 << YB) - 1, (1 << XB) - 1, 8'hC3);
    read_chk("R3 back not shown", 1, 2, 9'h100);
    strobe(1'b1, 1'b0);
    check("R4 set", {8'h0, buf_sel}, 9'h001);
    read_chk("R6 bg only", 1, 2, 9'h15A);
    read_chk("R6 fg over bg", 1, 3, 9'h033);
    read_chk("R5 fg FF dropped", 1, 4, 9'h044);
    read_chk("R5 bg FF stored", 1, 5, 9'h1FF);
    read_chk("R9 corner", (1 << YB) - 1, (1 << XB) - 1, 9'h1C3);
    read_chk("R9 neighbour clean", (1 << YB) - 2, (1 << XB) - 1, 9'h100);
  endtask

  task automatic t_strobes;
    strobe(1'b0, 1'b1);
    check("R4 clear", {8'h0, buf_sel}, 9'h000);
    read_chk("R3 front is other bank", 1, 2, 9'h100);
    @(negedge clk);
    check("R4 hold", {8'h0, buf_sel}, 9'h000);
    strobe(1'b1, 1'b1);
    check("R4 both set wins", {8'h0, buf_sel}, 9'h001);
  endtask

  task automatic t_same_cycle;
    hwrite(1'b0, 2, 9, 8'h21);
    strobe(1'b0, 1'b1);
    read_chk("R3 after flip", 2, 9, 9'h121);
    @(negedge clk);
    wr_en = 1'b1; wr_fg = 1'b0; wr_addr = {3'd2, 5'd9}; wr_data = 8'h99;
    scan_x = 5'd9; scan_y = 3'd2;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R8 read unaffected", scan_index, 9'h121);
    strobe(1'b1, 1'b0);
    read_chk("R8 write landed", 2, 9, 9'h199);
  endtask

  task automatic t_latency;
    read_chk("R7 prime", 1, 3, 9'h033);
    @(negedge clk);
    scan_x = 5'd2; scan_y = 3'd1;
    @(negedge clk);
    check("R7 one edge", scan_index, 9'h033);
    scan_x = 5'd4; scan_y = 3'd1;
    @(negedge clk);
    check("R7 two edges", scan_index, 9'h15A);
    @(negedge clk);
    check("R7 next pixel", scan_index, 9'h044);
  endtask

  initial begin
    #100_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_compose();
    t_strobes();
    t_same_cycle();
    t_latency();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule